// File: doc/BRIEF.md
# Sixteen-bit multi-cycle processor core

This block is a small 16-bit processor that runs each instruction over several clock cycles under a finite-state controller. It has eight general registers, an arithmetic/logic unit with eight functions and a one-position shifter. Holding registers sit between the steps: program counter, instruction, two operand latches, a memory address register, a memory data register and a result latch. Instructions and data live in two separate internal word arrays.

There are four instruction classes, chosen by the two top bits of the 16-bit word. A register operation sends two registers through an ALU function, passes the result through a shift mode and writes it back. A load reads data memory at a register base plus a signed 8-bit byte offset. A store writes data memory at that same kind of address. A conditional branch compares selected condition flags against wanted values. The flags are captured only by register operations.

The core advances only while `run` is high. While it is low, a test harness can fill either memory through a word-wide load port and can read any data word through a combinational peek port. `retire_o` marks the last cycle of every instruction.

Top module: `mc16_core`

## Requirements
- R1: After reset is released, the program counter reads 0, `flags_o` reads 0000 and execution begins with an instruction fetch from word 0; reset clears any flags left by earlier code.
- R2: The ALU function field (instruction bits [4:2]) selects: 000 pass first operand (the register named by bits [10:8]), 001 pass second operand (the register named by bits [13:11]), 010 sum, 011 first minus second, 100 invert first, 101 invert second, 110 bitwise AND, 111 bitwise OR.
- R3: The shift field (bits [1:0]) is applied to the ALU result: 00 unchanged, 01 left by one with a zero fill, 10 right by one with a zero fill, 11 right by one copying the sign bit.
- R4: A register operation (bits [15:14]=00; fields [13:11] second source, [10:8] first source, [7:5] destination) writes the shifted result to the destination register, adds 2 to the program counter and takes 4 cycles.
- R5: A load (bits [15:14]=01; [13:11] destination, [10:8] base, [7:0] signed byte offset) writes the data word at byte address base plus the sign-extended offset into the destination register, advances the program counter by 2 and takes 5 cycles. Memory words are addressed by address bits above bit 0.
- R6: A store (bits [15:14]=10; same field layout as a load, [13:11] naming the data register) writes that register to data memory at the computed address, advances the program counter by 2 and takes 4 cycles.
- R7: `flags_o` is {Z,S,C,V}, taken from the ALU result before the shift. Z means the result is zero and S is its top bit. C is the carry out of a sum or the borrow of a difference, and is 0 for all other functions. V is the signed overflow of a sum or difference, and is 0 for all other functions.
- R8: The flags change only in the execute cycle of a register operation; loads, stores and branches leave them unchanged.
- R9: A branch (bits [15:14]=11; [13:10] mask for Z,S,C,V; [9:6] wanted values in the same order; [5:0] signed word offset) is taken when every masked flag equals its wanted value. Taken, the program counter becomes the branch address + 2 + 2*offset; not taken, it becomes the branch address + 2. A branch takes 3 cycles.
- R10: While `run` is low, the program counter, flags and controller state hold. The load port writes the instruction array (`ld_dmem`=0) or the data array (`ld_dmem`=1) at a word index, and `peek_data` shows the data word at `peek_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Clock enable for the whole core |
| ld_we | input | 1 | Load-port write strobe |
| ld_dmem | input | 1 | Load-port target: 0 instruction array, 1 data array |
| ld_addr | input | MEM_AW | Load-port word index |
| ld_data | input | 16 | Load-port write word |
| peek_addr | input | MEM_AW | Data-array word index to observe |
| peek_data | output | 16 | Data word at `peek_addr` |
| pc_o | output | 16 | Program counter |
| flags_o | output | 4 | Latched flags {Z,S,C,V} |
| retire_o | output | 1 | High in the final cycle of an instruction while running |

## Verification
The embedded properties check these on every cycle: the program counter steps by 2 on each fetch; it stays put on an untaken branch and whenever `run` is low; the flags stay still outside a register execute cycle; a register write lands in the file on the next cycle; and every final cycle is followed by a fetch. The bench scenarios alone show the arithmetic: the function and shift results and the carry, borrow and overflow values across sign and wrap boundaries. They also show load addressing with a negative offset, the skipping of instructions by a taken branch, backward branch targets, and the exact cycle count of each instruction class.

// File: rtl/mc16_pkg.sv
`timescale 1ns/1ps
package mc16_pkg;

  localparam int XLEN = 16;

  typedef enum logic [1:0] {
    OP_REG    = 2'b00,
    OP_LOAD   = 2'b01,
    OP_STORE  = 2'b10,
    OP_BRANCH = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    AF_PASSA = 3'b000,
    AF_PASSB = 3'b001,
    AF_ADD   = 3'b010,
    AF_SUB   = 3'b011,
    AF_NOTA  = 3'b100,
    AF_NOTB  = 3'b101,
    AF_AND   = 3'b110,
    AF_OR    = 3'b111
  } alu_fn_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'b00,
    SH_LEFT = 2'b01,
    SH_RLOG = 2'b10,
    SH_RARI = 2'b11
  } sh_e;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_DECODE,
    ST_REG_EX,
    ST_REG_WB,
    ST_ADDR,
    ST_LD_MEM,
    ST_LD_WB,
    ST_ST_MEM,
    ST_BR
  } state_e;

  typedef struct packed {
    logic z;
    logic s;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/mc16_regfile.sv
`timescale 1ns/1ps
module mc16_regfile #(
  parameter int W     = 16,
  parameter int NREGS = 8,
  localparam int RAW  = $clog2(NREGS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RAW-1:0] ra_a,
  input  logic [RAW-1:0] ra_b,
  output logic [W-1:0]   rd_a,
  output logic [W-1:0]   rd_b,
  input  logic           we,
  input  logic [RAW-1:0] wa,
  input  logic [W-1:0]   wd
);

  logic [W-1:0] regs_q [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (we) begin
      regs_q[wa] <= wd;
    end
  end

  assign rd_a = regs_q[ra_a];
  assign rd_b = regs_q[ra_b];

  // R4: a written value is visible at the addressed entry one cycle later
  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (regs_q[$past(wa)] == $past(wd)));

endmodule

// File: rtl/mc16_alu.sv
`timescale 1ns/1ps
module mc16_alu
  import mc16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output flags_t       fl
);

  logic [W:0] wide;

  always_comb begin
    wide = '0;
    y    = '0;
    fl.c = 1'b0;
    fl.v = 1'b0;
    case (fn)
      AF_PASSA: y = a;
      AF_PASSB: y = b;
      AF_ADD: begin
        wide = {1'b0, a} + {1'b0, b};
        y    = wide[W-1:0];
        fl.c = wide[W];
        fl.v = (a[W-1] == b[W-1]) && (y[W-1] != a[W-1]);
      end
      AF_SUB: begin
        wide = {1'b0, a} - {1'b0, b};
        y    = wide[W-1:0];
        fl.c = wide[W];
        fl.v = (a[W-1] != b[W-1]) && (y[W-1] != a[W-1]);
      end
      AF_NOTA: y = ~a;
      AF_NOTB: y = ~b;
      AF_AND:  y = a & b;
      AF_OR:   y = a | b;
      default: y = '0;
    endcase
    fl.z = (y == '0);
    fl.s = y[W-1];
  end

endmodule

// File: rtl/mc16_shift.sv
`timescale 1ns/1ps
module mc16_shift
  import mc16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  sh_e          mode,
  output logic [W-1:0] y
);

  always_comb begin
    case (mode)
      SH_LEFT: y = {x[W-2:0], 1'b0};
      SH_RLOG: y = {1'b0, x[W-1:1]};
      SH_RARI: y = {x[W-1], x[W-1:1]};
      default: y = x;
    endcase
  end

endmodule

// File: rtl/mc16_ctrl.sv
`timescale 1ns/1ps
module mc16_ctrl
  import mc16_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  op_e    op,
  output state_e state,
  output logic   ir_we,
  output logic   pc_inc,
  output logic   ab_we,
  output logic   res_we,
  output logic   mar_we,
  output logic   mdr_we,
  output logic   rf_we,
  output logic   rf_from_mem,
  output logic   dmem_we,
  output logic   br_eval,
  output logic   alu_use_func,
  output logic   retire
);

  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        case (op)
          OP_REG:    state_d = ST_REG_EX;
          OP_BRANCH: state_d = ST_BR;
          default:   state_d = ST_ADDR;
        endcase
      end
      ST_REG_EX: state_d = ST_REG_WB;
      ST_ADDR:   state_d = (op == OP_LOAD) ? ST_LD_MEM : ST_ST_MEM;
      ST_LD_MEM: state_d = ST_LD_WB;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state_q <= ST_FETCH;
    else if (run) state_q <= state_d;
  end

  logic last_step;

  always_comb begin
    last_step    = (state_q == ST_REG_WB) || (state_q == ST_LD_WB) ||
                   (state_q == ST_ST_MEM) || (state_q == ST_BR);
    ir_we        = run && (state_q == ST_FETCH);
    pc_inc       = run && (state_q == ST_FETCH);
    ab_we        = run && (state_q == ST_DECODE);
    res_we       = run && (state_q == ST_REG_EX);
    mar_we       = run && (state_q == ST_ADDR);
    mdr_we       = run && (state_q == ST_LD_MEM);
    rf_we        = run && ((state_q == ST_REG_WB) || (state_q == ST_LD_WB));
    rf_from_mem  = (state_q == ST_LD_WB);
    dmem_we      = run && (state_q == ST_ST_MEM);
    br_eval      = run && (state_q == ST_BR);
    alu_use_func = (state_q == ST_REG_EX);
    retire       = run && last_step;
  end

  assign state = state_q;

  // R1: each final cycle hands over to a fresh fetch
  p_retire_to_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (state_q == ST_FETCH));

  // R10: the controller holds its state while not running
  p_state_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(state_q));

endmodule

// File: rtl/mc16_core.sv
`timescale 1ns/1ps
module mc16_core
  import mc16_pkg::*;
#(
  parameter int MEM_AW = 6,
  parameter int NREGS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ld_we,
  input  logic              ld_dmem,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [15:0]       ld_data,
  input  logic [MEM_AW-1:0] peek_addr,
  output logic [15:0]       peek_data,
  output logic [15:0]       pc_o,
  output logic [3:0]        flags_o,
  output logic              retire_o
);

  localparam int W      = XLEN;
  localparam int DEPTH  = 2 ** MEM_AW;
  localparam int RAW    = $clog2(NREGS);
  localparam int NFLAGS = 4;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // storage arrays
  logic [W-1:0] imem [DEPTH];
  logic [W-1:0] dmem [DEPTH];

  // holding registers
  logic [W-1:0] pc_q, ir_q, a_q, b_q, mar_q, mdr_q, res_q;
  flags_t       flags_q;

  // controller strobes
  state_e st;
  logic   ir_we, pc_inc, ab_we, res_we, mar_we, mdr_we;
  logic   rf_we, rf_from_mem, dmem_we, br_eval, alu_use_func, retire;

  // instruction fields
  op_e            op;
  logic [RAW-1:0] f_rd, f_rs, f_rt;
  alu_fn_e        f_fn;
  sh_e            f_sh;
  logic [7:0]     f_imm8;
  logic [3:0]     f_mask, f_want;
  logic [5:0]     f_imm6;

  assign op     = op_e'(ir_q[15:14]);
  assign f_rd   = ir_q[13:11];
  assign f_rs   = ir_q[10:8];
  assign f_rt   = ir_q[7:5];
  assign f_fn   = alu_fn_e'(ir_q[4:2]);
  assign f_sh   = sh_e'(ir_q[1:0]);
  assign f_imm8 = ir_q[7:0];
  assign f_mask = ir_q[13:10];
  assign f_want = ir_q[9:6];
  assign f_imm6 = ir_q[5:0];

  mc16_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .run          (run),
    .op           (op),
    .state        (st),
    .ir_we        (ir_we),
    .pc_inc       (pc_inc),
    .ab_we        (ab_we),
    .res_we       (res_we),
    .mar_we       (mar_we),
    .mdr_we       (mdr_we),
    .rf_we        (rf_we),
    .rf_from_mem  (rf_from_mem),
    .dmem_we      (dmem_we),
    .br_eval      (br_eval),
    .alu_use_func (alu_use_func),
    .retire       (retire)
  );

  // register file
  logic [W-1:0]   rf_a, rf_b, rf_wd;
  logic [RAW-1:0] rf_wa;

  assign rf_wa = rf_from_mem ? f_rd : f_rt;
  assign rf_wd = rf_from_mem ? mdr_q : res_q;

  mc16_regfile #(.W(W), .NREGS(NREGS)) u_rf (
    .clk   (clk),
    .rst_n (rst_core_n),
    .ra_a  (f_rs),
    .ra_b  (f_rd),
    .rd_a  (rf_a),
    .rd_b  (rf_b),
    .we    (rf_we),
    .wa    (rf_wa),
    .wd    (rf_wd)
  );

  // ALU and shifter
  logic [W-1:0] sext8, alu_b, alu_y, sh_y;
  alu_fn_e      alu_fn;
  flags_t       alu_fl;

  assign sext8  = {{(W-8){f_imm8[7]}}, f_imm8};
  assign alu_b  = alu_use_func ? b_q : sext8;
  assign alu_fn = alu_use_func ? f_fn : AF_ADD;

  mc16_alu #(.W(W)) u_alu (
    .a  (a_q),
    .b  (alu_b),
    .fn (alu_fn),
    .y  (alu_y),
    .fl (alu_fl)
  );

  mc16_shift #(.W(W)) u_shift (
    .x    (alu_y),
    .mode (f_sh),
    .y    (sh_y)
  );

  // branch decision and target
  logic         cond_ok;
  logic [W-1:0] br_off, pc_d;
  logic         pc_we;

  always_comb begin
    cond_ok = 1'b1;
    for (int i = 0; i < NFLAGS; i++) begin
      if (f_mask[i] && (f_want[i] != flags_q[i])) cond_ok = 1'b0;
    end
  end

  assign br_off = {{(W-7){f_imm6[5]}}, f_imm6, 1'b0};
  assign pc_we  = pc_inc || (br_eval && cond_ok);
  assign pc_d   = br_eval ? (pc_q + br_off) : (pc_q + 16'd2);

  // datapath registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pc_q    <= '0;
      ir_q    <= '0;
      a_q     <= '0;
      b_q     <= '0;
      mar_q   <= '0;
      mdr_q   <= '0;
      res_q   <= '0;
      flags_q <= '0;
    end else begin
      if (pc_we)  pc_q  <= pc_d;
      if (ir_we)  ir_q  <= imem[pc_q[MEM_AW:1]];
      if (ab_we) begin
        a_q <= rf_a;
        b_q <= rf_b;
      end
      if (res_we) begin
        res_q   <= sh_y;
        flags_q <= alu_fl;
      end
      if (mar_we) mar_q <= alu_y;
      if (mdr_we) mdr_q <= dmem[mar_q[MEM_AW:1]];
    end
  end

  // memory writes
  always_ff @(posedge clk) begin
    if (ld_we && !ld_dmem) imem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (dmem_we)             dmem[mar_q[MEM_AW:1]] <= b_q;
    else if (ld_we && ld_dmem) dmem[ld_addr] <= ld_data;
  end

  logic unused_addr_bits;
  assign unused_addr_bits = ^{mar_q[W-1:MEM_AW+1], mar_q[0], pc_q[0]};

  assign peek_data = dmem[peek_addr];
  assign pc_o      = pc_q;
  assign flags_o   = flags_q;
  assign retire_o  = retire;

  // R4: each fetch advances the program counter by two
  p_fetch_step_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run && st == ST_FETCH) |=> (pc_q == $past(pc_q) + 16'd2));

  // R8: flags move only out of a register execute cycle
  p_flags_quiet_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(run && st == ST_REG_EX) |=> $stable(flags_q));

  // R9: an untaken branch leaves the program counter alone
  p_branch_untaken_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run && st == ST_BR && !cond_ok) |=> $stable(pc_q));

  // R10: nothing architectural moves while not running
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    !run |=> ($stable(pc_q) && $stable(flags_q)));

endmodule

// File: tb/test_mc16_core.sv
`timescale 1ns/1ps
module test_mc16_core;

  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n, run, ld_we, ld_dmem;
  logic [AW-1:0] ld_addr, peek_addr;
  logic [15:0]   ld_data, peek_data, pc_o;
  logic [3:0]    flags_o;
  logic          retire_o;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  always #4 clk = ~clk;

  mc16_core #(.MEM_AW(AW)) i_mc16_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .ld_we     (ld_we),
    .ld_dmem   (ld_dmem),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .peek_addr (peek_addr),
    .peek_data (peek_data),
    .pc_o      (pc_o),
    .flags_o   (flags_o),
    .retire_o  (retire_o)
  );

  // {first operand, second operand, function, shift, expected result, expected {Z,S,C,V}}
  localparam logic [56:0] VEC [12] = '{
    {16'h1234, 16'h0111, 3'd2, 2'd0, 16'h1345, 4'b0000},
    {16'hFFFF, 16'h0001, 3'd2, 2'd0, 16'h0000, 4'b1010},
    {16'h7FFF, 16'h0001, 3'd2, 2'd2, 16'h4000, 4'b0101},
    {16'h0005, 16'h0007, 3'd3, 2'd3, 16'hFFFF, 4'b0110},
    {16'h8000, 16'h0001, 3'd3, 2'd1, 16'hFFFE, 4'b0001},
    {16'h00AA, 16'h00AA, 3'd3, 2'd0, 16'h0000, 4'b1000},
    {16'h8001, 16'h1234, 3'd0, 2'd3, 16'hC000, 4'b0100},
    {16'h1111, 16'h00F0, 3'd1, 2'd1, 16'h01E0, 4'b0000},
    {16'h0F0F, 16'h0000, 3'd4, 2'd2, 16'h7878, 4'b0100},
    {16'h1234, 16'hFFFF, 3'd5, 2'd0, 16'h0000, 4'b1000},
    {16'hF0F0, 16'h3C3C, 3'd6, 2'd0, 16'h3030, 4'b0000},
    {16'h8000, 16'h0001, 3'd7, 2'd2, 16'h4000, 4'b0100}
  };

  function automatic logic [15:0] enc_r(input logic [2:0] rd, input logic [2:0] rs,
                                        input logic [2:0] rt, input logic [2:0] fn,
                                        input logic [1:0] sh);
    return {2'b00, rd, rs, rt, fn, sh};
  endfunction

  function automatic logic [15:0] enc_m(input logic [1:0] op, input logic [2:0] rd,
                                        input logic [2:0] rs, input logic [7:0] imm);
    return {op, rd, rs, imm};
  endfunction

  function automatic logic [15:0] enc_b(input logic [3:0] m, input logic [3:0] v,
                                        input logic [5:0] imm);
    return {2'b11, m, v, imm};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic dm, input int addr, input logic [15:0] data);
    ld_we   = 1'b1;
    ld_dmem = dm;
    ld_addr = AW'(addr);
    ld_data = data;
    @(negedge clk);
    ld_we   = 1'b0;
  endtask

  task automatic peek(input int addr, output logic [15:0] data);
    peek_addr = AW'(addr);
    #1;
    data = peek_data;
  endtask

  task automatic reset_core();
    run   = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // runs one instruction from its fetch cycle; returns cycles used and the next pc
  task automatic step(output int cyc, output logic [15:0] pc_next);
    cyc = 1;
    while (!retire_o) begin
      @(negedge clk);
      cyc++;
    end
    @(negedge clk);
    pc_next = pc_o;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int          cyc;
    logic [15:0] pcn, word;

    rst_n = 1'b0; run = 1'b0; ld_we = 1'b0; ld_dmem = 1'b0;
    ld_addr = '0; ld_data = '0; peek_addr = '0;
    @(negedge clk);
    reset_core();
    check("R1 pc after reset", pc_o, 16'h0000);
    check("R1 flags after reset", flags_o, 4'b0000);

    // vector walk: LD r1; LD r2; r3 <- op(r1, r2); ST r3
    for (int v = 0; v < 12; v++) begin
      put(1'b1, 0, VEC[v][56:41]);
      put(1'b1, 1, VEC[v][40:25]);
      put(1'b1, 2, 16'hDEAD);
      put(1'b0, 0, enc_m(2'b01, 3'd1, 3'd0, 8'd0));
      put(1'b0, 1, enc_m(2'b01, 3'd2, 3'd0, 8'd2));
      put(1'b0, 2, enc_r(3'd2, 3'd1, 3'd3, VEC[v][24:22], VEC[v][21:20]));
      put(1'b0, 3, enc_m(2'b10, 3'd3, 3'd0, 8'd4));
      reset_core();
      run = 1'b1;
      step(cyc, pcn);
      if (v == 0) begin
        check("R5 load cycles", 32'(cyc), 32'd5);
        check("R5 pc after load", pcn, 16'd2);
      end
      step(cyc, pcn);
      step(cyc, pcn);
      if (v == 0) begin
        check("R4 register op cycles", 32'(cyc), 32'd4);
        check("R4 pc after register op", pcn, 16'd6);
      end
      step(cyc, pcn);
      if (v == 0) begin
        check("R6 store cycles", 32'(cyc), 32'd4);
        check("R6 pc after store", pcn, 16'd8);
      end
      run = 1'b0;
      peek(2, word);
      check($sformatf("R2 R3 R4 R6 result vector %0d", v), word, VEC[v][19:4]);
      check($sformatf("R7 flags vector %0d", v), flags_o, VEC[v][3:0]);
    end

    // R1: reset wipes flags left by the last vector
    reset_core();
    check("R1 pc after second reset", pc_o, 16'h0000);
    check("R1 flags cleared by reset", flags_o, 4'b0000);

    // directed: branches, negative offset load, flag stability
    put(1'b1, 0, 16'h00AA);
    put(1'b1, 1, 16'h00AA);
    put(1'b1, 3, 16'h0010);
    put(1'b1, 5, 16'h5A5A);
    put(1'b1, 7, 16'h0000);
    put(1'b1, 8, 16'h0000);
    put(1'b0, 0, enc_m(2'b01, 3'd1, 3'd0, 8'd0));
    put(1'b0, 1, enc_m(2'b01, 3'd2, 3'd0, 8'd2));
    put(1'b0, 2, enc_r(3'd2, 3'd1, 3'd3, 3'd3, 2'd0));
    put(1'b0, 3, enc_b(4'b1000, 4'b1000, 6'd2));
    put(1'b0, 4, enc_m(2'b10, 3'd1, 3'd0, 8'd14));
    put(1'b0, 5, enc_m(2'b10, 3'd1, 3'd0, 8'd14));
    put(1'b0, 6, enc_m(2'b01, 3'd5, 3'd0, 8'd6));
    put(1'b0, 7, enc_m(2'b01, 3'd4, 3'd5, 8'hFA));
    put(1'b0, 8, enc_m(2'b10, 3'd4, 3'd0, 8'd16));
    put(1'b0, 9, enc_b(4'b0010, 4'b0010, 6'h3E));
    put(1'b0, 10, enc_b(4'b0000, 4'b0000, 6'h3F));
    reset_core();
    run = 1'b1;
    step(cyc, pcn);
    step(cyc, pcn);
    step(cyc, pcn);
    check("R7 zero flag from equal difference", flags_o, 4'b1000);
    step(cyc, pcn);
    check("R9 branch cycles", 32'(cyc), 32'd3);
    check("R9 taken branch target", pcn, 16'd12);
    check("R8 flags after branch", flags_o, 4'b1000);
    step(cyc, pcn);
    step(cyc, pcn);
    step(cyc, pcn);
    check("R8 flags after loads and store", flags_o, 4'b1000);
    step(cyc, pcn);
    check("R9 masked mismatch not taken", pcn, 16'd20);
    step(cyc, pcn);
    check("R9 empty mask taken backward", pcn, 16'd20);
    run = 1'b0;
    peek(7, word);
    check("R9 skipped stores left memory", word, 16'h0000);
    peek(8, word);
    check("R5 negative offset load", word, 16'h5A5A);

    // R10: idle core holds while the load port writes data
    pcn = pc_o;
    put(1'b1, 9, 16'hBEEF);
    repeat (5) @(negedge clk);
    check("R10 pc held while idle", pc_o, pcn);
    check("R10 flags held while idle", flags_o, 4'b1000);
    peek(9, word);
    check("R10 load port data write", word, 16'hBEEF);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule